// File: doc/BRIEF.md
# Predicate Partition and Active-Lane Counter

This block carries out the lane bookkeeping of a vector loop whose trip count is not known in advance, such as a scan for a terminating zero byte. It works on predicates that hold one bit per byte of the vector. The low bit of each element is the only bit that counts. All work is done under a governing predicate.

Four operations are offered:

- **Valid partition:** the first-fault status is ANDed with the governing predicate, giving the lanes that loaded successfully.
- **Break-before partition:** the active lanes that lie ahead of the first true condition lane are kept.
- **Count:** the active lanes of a source predicate are counted.
- **Increment:** that count is added to a 64-bit scalar.

The two predicate operations can also produce NZCV condition flags from their result. Loop control can then branch on "any", "first" or "last active lane" without any further instruction.

The first-fault status lives inside the block. A set pulse fills it with ones. A fault pulse reports the lane of the first failing element, and every lane from that one upward is cleared. Operations are issued with a one-cycle strobe, and the result registers update on the next clock edge.

Top module: `pred_part_unit`

## Requirements
- R1: With `op`=1 (break-before), a result bit is 1 when its lane is active in the effective governing predicate and no active lane at or below it has its condition bit (`src`) set. The lane holding the first true condition and every later lane are 0, and so are all inactive lanes.
- R2: With `op`=1, when no active lane has its condition set, the result equals the effective governing predicate.
- R3: With `op`=0 (valid partition), the result is the stored first-fault status ANDed with the effective governing predicate.
- R4: `esz` encodes element size as 0=8, 1=16, 2=32, 3=64 bits. A predicate bit i is significant only when i is a multiple of the element's byte count (1, 2, 4 or 8). Bits that are not significant are dropped from `gov` and are 0 in every predicate result.
- R5: With `op`=2 (count), `scalar_out` becomes the number of significant lanes set in both `gov` and `src`, zero-extended.
- R6: With `op`=3 (increment), `scalar_out` becomes `scalar_in` plus that count, modulo 2^64.
- R7: On a predicate operation with `set_flags`=1, the flags are set from the result over the active lanes. `nzcv`[3]=N is 1 when the first active lane is true. `nzcv`[2]=Z is 1 when no active lane is true. `nzcv`[1]=C is 0 when the last active lane is true. `nzcv`[0]=V is always 0. With no active lanes the flags are N=0, Z=1, C=1.
- R8: `nzcv` holds when `set_flags`=0 or when a count or increment is issued. `pred_out` holds across count and increment operations. `scalar_out` holds across predicate operations.
- R9: A `ffr_set` pulse sets every first-fault status lane to 1, and it wins over a fault reported in the same cycle.
- R10: A `fault_vld` pulse with lane k>0 clears status lanes k and above, and faults accumulate. A fault at lane 0 is ignored, because the first element is mandatory.
- R11: Results, flags and `res_vld` appear on the clock edge that samples `op_vld`. A status update made on one edge is seen by a valid-partition operation issued in the next cycle.
- R12: After reset `pred_out`, `scalar_out`, `nzcv` and `res_vld` are 0, and the first-fault status is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_vld | input | 1 | Issues an operation this cycle |
| op | input | 2 | 0 valid partition, 1 break-before, 2 count, 3 increment |
| esz | input | 2 | Element size code |
| set_flags | input | 1 | Update NZCV from a predicate result |
| gov | input | PW | Governing predicate |
| src | input | PW | Condition or source predicate |
| scalar_in | input | SW | Scalar addend for increment |
| ffr_set | input | 1 | Reinitialise first-fault status to all ones |
| fault_vld | input | 1 | A fault is reported this cycle |
| fault_lane | input | LW | Predicate-bit index of the first failing element |
| res_vld | output | 1 | Result registers were updated on the last edge |
| pred_out | output | PW | Predicate result |
| scalar_out | output | SW | Count or incremented scalar |
| nzcv | output | 4 | Condition flags N, Z, C, V from bit 3 down |

## Verification
Every result is due exactly one clock edge after the cycle in which `op_vld` is high. The bench drives inputs on the falling edge, drops the strobe on the next falling edge, and samples `pred_out`, `scalar_out`, `nzcv` and `res_vld` at that moment. A first-fault status change made by a set or fault pulse is first seen one cycle after the pulse. The bench therefore finishes each pulse before it issues the valid-partition operation that reveals the change. Hold behaviour is checked by sampling outputs that an operation must leave alone, in the same one-cycle window.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
   typedef enum logic [1:0] {
      OP_VALID = 2'd0,
      OP_BRKB  = 2'd1,
      OP_CNT   = 2'd2,
      OP_INCP  = 2'd3
   } ppc_op_e;

   typedef enum logic [1:0] {
      ESZ_8  = 2'd0,
      ESZ_16 = 2'd1,
      ESZ_32 = 2'd2,
      ESZ_64 = 2'd3
   } ppc_esz_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } ppc_flags_t;
endpackage

// File: rtl/ppc_elem_mask.sv
// Marks the predicate bits that are significant for the selected element size.
module ppc_elem_mask #(
   parameter int PW = 16
) (
   input  logic [1:0]    esz,
   output logic [PW-1:0] mask
);
   for (genvar i = 0; i < PW; i++) begin : g_lane
      localparam bit AL2 = (i % 2) == 0;
      localparam bit AL4 = (i % 4) == 0;
      localparam bit AL8 = (i % 8) == 0;
      assign mask[i] = (esz == ppc_pkg::ESZ_8)
                    || (esz == ppc_pkg::ESZ_16 && AL2)
                    || (esz == ppc_pkg::ESZ_32 && AL4)
                    || AL8;
   end
endmodule

// File: rtl/ppc_brk_before.sv
// Keeps active lanes strictly ahead of the first active true condition.
module ppc_brk_before #(
   parameter int PW = 16
) (
   input  logic [PW-1:0] act,
   input  logic [PW-1:0] cond,
   output logic [PW-1:0] res
);
   always_comb begin
      logic hit;
      hit = 1'b0;
      for (int i = 0; i < PW; i++) begin
         hit    = hit | (act[i] & cond[i]);
         res[i] = act[i] & ~hit;
      end
   end
endmodule

// File: rtl/ppc_flag_gen.sv
// Derives N, Z, C, V from a predicate result over the active lanes.
module ppc_flag_gen #(
   parameter int PW = 16
) (
   input  logic [PW-1:0]      act,
   input  logic [PW-1:0]      pred,
   output ppc_pkg::ppc_flags_t flags
);
   always_comb begin
      logic seen_first;
      logic first_val;
      logic last_val;
      seen_first = 1'b0;
      first_val  = 1'b0;
      last_val   = 1'b0;
      for (int i = 0; i < PW; i++) begin
         if (act[i]) begin
            if (!seen_first) first_val = pred[i];
            seen_first = 1'b1;
            last_val   = pred[i];
         end
      end
      flags.n = first_val;
      flags.z = ~|(pred & act);
      flags.c = ~last_val;
      flags.v = 1'b0;
   end
endmodule

// File: rtl/ppc_lane_count.sv
// Population count of a predicate.
module ppc_lane_count #(
   parameter int PW = 16,
   localparam int CW = $clog2(PW + 1)
) (
   input  logic [PW-1:0] bits,
   output logic [CW-1:0] cnt
);
   always_comb begin
      cnt = '0;
      for (int i = 0; i < PW; i++) cnt = cnt + CW'(bits[i]);
   end
endmodule

// File: rtl/pred_part_unit.sv
module pred_part_unit #(
   parameter int PW = 16,
   parameter int SW = 64,
   localparam int LW = $clog2(PW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          op_vld,
   input  logic [1:0]    op,
   input  logic [1:0]    esz,
   input  logic          set_flags,
   input  logic [PW-1:0] gov,
   input  logic [PW-1:0] src,
   input  logic [SW-1:0] scalar_in,
   input  logic          ffr_set,
   input  logic          fault_vld,
   input  logic [LW-1:0] fault_lane,
   output logic          res_vld,
   output logic [PW-1:0] pred_out,
   output logic [SW-1:0] scalar_out,
   output logic [3:0]    nzcv
);
   import ppc_pkg::*;

   localparam int CW = $clog2(PW + 1);

   if (PW < 8 || (PW % 8) != 0) begin : g_bad_pw
      $error("pred_part_unit: PW must be a positive multiple of 8");
   end
   if (SW < CW) begin : g_bad_sw
      $error("pred_part_unit: SW too narrow for the lane count");
   end

   ppc_op_e       op_e;
   logic [PW-1:0] elem_mask;
   logic [PW-1:0] act;
   logic [PW-1:0] brk_res;
   logic [PW-1:0] part_res;
   logic [PW-1:0] cnt_bits;
   logic [CW-1:0] cnt;
   logic [SW-1:0] cnt_ext;
   logic [PW-1:0] ffr_q;
   logic [PW-1:0] fault_keep;
   ppc_flags_t    flg;
   logic          is_pred_op;

   assign op_e       = ppc_op_e'(op);
   assign is_pred_op = (op_e == OP_VALID) || (op_e == OP_BRKB);

   ppc_elem_mask #(.PW(PW)) u_mask (.esz(esz), .mask(elem_mask));
   assign act = gov & elem_mask;

   ppc_brk_before #(.PW(PW)) u_brk (.act(act), .cond(src), .res(brk_res));

   assign part_res = (op_e == OP_BRKB) ? brk_res : (ffr_q & act);

   ppc_flag_gen #(.PW(PW)) u_flags (.act(act), .pred(part_res), .flags(flg));

   assign cnt_bits = src & act;
   ppc_lane_count #(.PW(PW)) u_cnt (.bits(cnt_bits), .cnt(cnt));
   assign cnt_ext = {{(SW - CW){1'b0}}, cnt};

   // Lanes below the reported fault survive.
   for (genvar i = 0; i < PW; i++) begin : g_keep
      assign fault_keep[i] = (LW'(i) < fault_lane);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ffr_q <= '1;
      end else if (ffr_set) begin
         ffr_q <= '1;
      end else if (fault_vld && fault_lane != '0) begin
         ffr_q <= ffr_q & fault_keep;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_vld    <= 1'b0;
         pred_out   <= '0;
         scalar_out <= '0;
         nzcv       <= '0;
      end else begin
         res_vld <= op_vld;
         if (op_vld) begin
            if (is_pred_op) begin
               pred_out <= part_res;
               if (set_flags) nzcv <= flg;
            end else if (op_e == OP_CNT) begin
               scalar_out <= cnt_ext;
            end else begin
               scalar_out <= scalar_in + cnt_ext;
            end
         end
      end
   end
endmodule

// File: rtl/pred_part_unit_chk.sv
module pred_part_unit_chk #(
   parameter int PW = 16,
   parameter int SW = 64,
   localparam int LW = $clog2(PW)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          op_vld,
   input logic [1:0]    op,
   input logic          set_flags,
   input logic [PW-1:0] gov,
   input logic          ffr_set,
   input logic          fault_vld,
   input logic [LW-1:0] fault_lane,
   input logic          res_vld,
   input logic [PW-1:0] pred_out,
   input logic [SW-1:0] scalar_out,
   input logic [3:0]    nzcv,
   input logic [PW-1:0] ffr_q
);
   // R11
   res_vld_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_vld |=> res_vld);

   // R11
   res_vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_vld |=> !res_vld);

   // R1
   pred_inside_gov_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_vld && op[1] == 1'b0) |=> ((pred_out & ~$past(gov)) == '0));

   // R7
   v_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nzcv[0] == 1'b0);

   // R7
   z_matches_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_vld && op[1] == 1'b0 && set_flags) |=> (nzcv[2] == (pred_out == '0)));

   // R5
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_vld && op == 2'd2) |=> (scalar_out <= SW'(PW)));

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_vld |=> ($stable(pred_out) && $stable(scalar_out) && $stable(nzcv)));

   // R9
   ffr_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ffr_set |=> (ffr_q == '1));

   // R10
   lane0_fault_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_vld && fault_lane == '0 && !ffr_set) |=> $stable(ffr_q));

   // R10
   fault_only_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ffr_set |=> ((ffr_q & ~$past(ffr_q)) == '0));
endmodule

bind pred_part_unit pred_part_unit_chk #(.PW(PW), .SW(SW)) u_chk (.*);

// File: tb/pred_part_unit_bench.sv
module pred_part_unit_bench;
   localparam int PW = 16;
   localparam int SW = 64;
   localparam int LW = $clog2(PW);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          op_vld = 1'b0;
   logic [1:0]    op = '0;
   logic [1:0]    esz = '0;
   logic          set_flags = 1'b0;
   logic [PW-1:0] gov = '0;
   logic [PW-1:0] src = '0;
   logic [SW-1:0] scalar_in = '0;
   logic          ffr_set = 1'b0;
   logic          fault_vld = 1'b0;
   logic [LW-1:0] fault_lane = '0;
   logic          res_vld;
   logic [PW-1:0] pred_out;
   logic [SW-1:0] scalar_out;
   logic [3:0]    nzcv;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pred_part_unit #(.PW(PW), .SW(SW)) u_pred_part_unit (.*);

   typedef struct packed {
      logic [1:0]    op;
      logic [1:0]    esz;
      logic          sf;
      logic [15:0]   gov;
      logic [15:0]   src;
      logic [63:0]   sc;
      logic [15:0]   ep;
      logic [63:0]   es;
      logic [3:0]    ef;
   } vec_t;

   // nzcv = {N,Z,C,V}
   localparam vec_t VEC [10] = '{
      // R1: cut at lane 4
      '{2'd1, 2'd0, 1'b1, 16'hFFFF, 16'h0010, 64'd0, 16'h000F, 64'd0, 4'b1010},
      // R2: no condition lane true
      '{2'd1, 2'd0, 1'b1, 16'h0F0F, 16'h0000, 64'd0, 16'h0F0F, 64'd0, 4'b1000},
      // R4: 32-bit elements
      '{2'd1, 2'd2, 1'b1, 16'hFFFF, 16'h0100, 64'd0, 16'h0011, 64'd0, 4'b1010},
      // R1: inactive true ignored, first active true -> empty
      '{2'd1, 2'd0, 1'b1, 16'hFF00, 16'h0101, 64'd0, 16'h0000, 64'd0, 4'b0110},
      // R3: valid partition with full status
      '{2'd0, 2'd0, 1'b1, 16'h00FF, 16'h0000, 64'd0, 16'h00FF, 64'd0, 4'b1000},
      // R5/R8: count at 16-bit elements, flags and pred hold
      '{2'd2, 2'd1, 1'b1, 16'hFFFF, 16'h0F0F, 64'd0, 16'h00FF, 64'd4, 4'b1000},
      // R6: increment
      '{2'd3, 2'd0, 1'b0, 16'hFFFF, 16'h8001, 64'd100, 16'h00FF, 64'd102, 4'b1000},
      // R6: wraps modulo 2^64 at 64-bit elements
      '{2'd3, 2'd3, 1'b0, 16'h0100, 16'hFFFF, 64'hFFFF_FFFF_FFFF_FFFF, 16'h00FF, 64'd0, 4'b1000},
      // R8: no flag update, scalar holds
      '{2'd1, 2'd0, 1'b0, 16'hFFFF, 16'h0001, 64'd0, 16'h0000, 64'd0, 4'b1000},
      // R7: no active lanes
      '{2'd1, 2'd0, 1'b1, 16'h0000, 16'hFFFF, 64'd0, 16'h0000, 64'd0, 4'b0110}
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [1:0] o, input logic [1:0] e, input logic sf,
                        input logic [PW-1:0] g, input logic [PW-1:0] s, input logic [SW-1:0] sc);
      @(negedge clk);
      op = o; esz = e; set_flags = sf; gov = g; src = s; scalar_in = sc; op_vld = 1'b1;
      @(negedge clk);
      op_vld = 1'b0;
   endtask

   task automatic status(input logic st, input logic fv, input logic [LW-1:0] fl);
      @(negedge clk);
      ffr_set = st; fault_vld = fv; fault_lane = fl;
      @(negedge clk);
      ffr_set = 1'b0; fault_vld = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R12
      chk("R12 pred", 64'(pred_out), 64'd0);
      chk("R12 scalar", scalar_out, 64'd0);
      chk("R12 flags", 64'(nzcv), 64'd0);
      chk("R12 vld", 64'(res_vld), 64'd0);
      rst_n = 1'b1;

      for (int k = 0; k < 10; k++) begin
         issue(VEC[k].op, VEC[k].esz, VEC[k].sf, VEC[k].gov, VEC[k].src, VEC[k].sc);
         chk($sformatf("vec%0d R11 vld", k), 64'(res_vld), 64'd1);
         chk($sformatf("vec%0d R1/R3 pred", k), 64'(pred_out), 64'(VEC[k].ep));
         chk($sformatf("vec%0d R5/R6 scalar", k), scalar_out, VEC[k].es);
         chk($sformatf("vec%0d R7/R8 flags", k), 64'(nzcv), 64'(VEC[k].ef));
      end
      @(negedge clk);
      chk("R11 vld drops", 64'(res_vld), 64'd0);

      // R12: status all ones after reset, seen by valid partition
      issue(2'd0, 2'd0, 1'b1, 16'hFFFF, 16'h0, 64'd0);
      chk("R12 status ones", 64'(pred_out), 64'hFFFF);
      chk("R7 full true flags", 64'(nzcv), 64'b1000);

      // R10: fault at lane 5
      status(1'b0, 1'b1, 4'd5);
      issue(2'd0, 2'd0, 1'b1, 16'hFFFF, 16'h0, 64'd0);
      chk("R10 fault lane5", 64'(pred_out), 64'h001F);
      chk("R7 partial flags", 64'(nzcv), 64'b1010);

      // R10: lane 0 fault ignored
      status(1'b0, 1'b1, 4'd0);
      issue(2'd0, 2'd0, 1'b0, 16'hFFFF, 16'h0, 64'd0);
      chk("R10 lane0 ignored", 64'(pred_out), 64'h001F);

      // R10: a later fault does not restore lanes
      status(1'b0, 1'b1, 4'd10);
      issue(2'd0, 2'd0, 1'b0, 16'hFFFF, 16'h0, 64'd0);
      chk("R10 cumulative", 64'(pred_out), 64'h001F);

      // R9: set refills
      status(1'b1, 1'b0, 4'd0);
      issue(2'd0, 2'd0, 1'b0, 16'hFFFF, 16'h0, 64'd0);
      chk("R9 refill", 64'(pred_out), 64'hFFFF);

      // R9: set wins over a simultaneous fault
      status(1'b1, 1'b1, 4'd3);
      issue(2'd0, 2'd0, 1'b0, 16'hFFFF, 16'h0, 64'd0);
      chk("R9 set priority", 64'(pred_out), 64'hFFFF);

      // R4/R3: fault at lane 9, 64-bit elements
      status(1'b0, 1'b1, 4'd9);
      issue(2'd0, 2'd3, 1'b1, 16'hFFFF, 16'h0, 64'd0);
      chk("R4 valid at 64-bit", 64'(pred_out), 64'h0101);
      chk("R7 flags at 64-bit", 64'(nzcv), 64'b1000);

      // R11: status change visible in the very next cycle
      @(negedge clk);
      ffr_set = 1'b0; fault_vld = 1'b1; fault_lane = 4'd1;
      @(negedge clk);
      fault_vld = 1'b0;
      op = 2'd0; esz = 2'd0; set_flags = 1'b0; gov = 16'hFFFF; op_vld = 1'b1;
      @(negedge clk);
      op_vld = 1'b0;
      chk("R11 status next cycle", 64'(pred_out), 64'h0001);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule